// File: doc/BRIEF.md
# Bus-mapped LED and switch peripheral

This block is a small peripheral slave on an APB bus. It holds two 32-bit registers that software loads with ordinary bus writes, and it reads back two switch inputs through the same bus. Bit 0 of the first register drives an LED output. Every transfer completes in its access cycle: the ready output is tied high and the error output is tied low. The block sees only the low 8 address bits.

Writes at offset 0x00 load register A and writes at offset 0x04 load register B. What a read returns at those two offsets depends on a build parameter. In switch mode, which is the default, a read returns the synchronized level of switch A or switch B as the value 0 or 1. In register mode, a read returns the stored register word. Every other offset reads as zero and ignores writes. Each switch input passes through a two-stage synchronizer before a read can see it.

Top module: `apb_led_sw`

## Requirements
- R1: `pready` is always 1 and `pslverr` is always 0, so every transfer finishes in its first access cycle with an OKAY response.
- R2: When `psel`, `penable` and `pwrite` are all 1 at a rising clock edge, the whole 32-bit `pwdata` word is loaded into register A if `paddr` is 0x00, or into register B if `paddr` is 0x04.
- R3: No register changes at an edge where any one of `psel`, `penable` or `pwrite` is 0. This covers a setup-only cycle, a cycle with `penable` high but no select, and a read transfer.
- R4: `led` equals bit 0 of register A. It changes at the same edge that writes register A.
- R5: With READ_SWITCH=1, a read at 0x00 returns the synchronized switch A level and a read at 0x04 returns switch B. The level sits in bit 0 and bits 31:1 are zero.
- R6: With READ_SWITCH=0, a read at 0x00 returns register A and a read at 0x04 returns register B.
- R7: A read at any offset other than 0x00 or 0x04 returns 0. A write to such an offset changes neither register.
- R8: While `presetn` is low, both registers clear to 0, `led` is 0 and the synchronizer stages clear to 0.
- R9: A switch level applied before a rising edge appears in read data only after the second rising edge, not after the first.
- R10: `prdata` is 0 whenever `psel` is 0 or `pwrite` is 1.

Read data is combinational from the address, so it is valid during the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock, rising edge |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Low address byte |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| sw_a | input | 1 | Switch A level, asynchronous |
| sw_b | input | 1 | Switch B level, asynchronous |
| led | output | 1 | LED drive, bit 0 of register A |

## Verification
In the default switch mode, register B cannot be read back and register A shows only bit 0, on the LED. A silent corruption of a stored word would therefore be invisible at the ports. The bench runs a second instance built in register mode on the same bus wires, so every write can be checked in full. With that pair it writes every one of the 256 offsets and reads every offset under all four switch combinations. The two-edge synchronizer delay is checked by holding a read selected and sampling read data after each edge. The bench also drives setup-only, select-less and read cycles that carry write data, to show that none of them stores anything.

// File: rtl/apb_led_sw_pkg.sv
package apb_led_sw_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned NUM_SW = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
    } regs_t;
endpackage

// File: rtl/apb_led_sw_sync.sv
module apb_led_sw_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned N      = 2
) (
    input  logic         clk,
    input  logic         rstn,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [STAGES-1:0][N-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = din;
        for (int s = 1; s < int'(STAGES); s++) begin
            sync_d[s] = sync_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) sync_q <= '0;
        else       sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/apb_led_sw_regs.sv
module apb_led_sw_regs
    import apb_led_sw_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFS_A = 8'h00,
    parameter logic [ADDR_W-1:0] OFS_B = 8'h04
) (
    input  logic              clk,
    input  logic              rstn,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    output regs_t             regs
);
    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == OFS_A) regs_d.a = wr_data;
            if (wr_addr == OFS_B) regs_d.b = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) regs_q <= '0;
        else       regs_q <= regs_d;
    end

    assign regs = regs_q;

    assert_write_a_R2: assert property (@(posedge clk) disable iff (!rstn)
        (wr_en && wr_addr == OFS_A) |=> regs_q.a == $past(wr_data));
    assert_write_b_R2: assert property (@(posedge clk) disable iff (!rstn)
        (wr_en && wr_addr == OFS_B) |=> regs_q.b == $past(wr_data));
    assert_no_strobe_R3: assert property (@(posedge clk) disable iff (!rstn)
        !wr_en |=> $stable(regs_q));
    assert_unmapped_wr_R7: assert property (@(posedge clk) disable iff (!rstn)
        (wr_en && wr_addr != OFS_A && wr_addr != OFS_B) |=> $stable(regs_q));
endmodule

// File: rtl/apb_led_sw_rdmux.sv
module apb_led_sw_rdmux
    import apb_led_sw_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFS_A = 8'h00,
    parameter logic [ADDR_W-1:0] OFS_B = 8'h04,
    parameter bit READ_SWITCH = 1'b1
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  regs_t             regs,
    input  logic [NUM_SW-1:0] sw,
    output word_t             rdata
);
    word_t src_a, src_b;

    generate
        if (READ_SWITCH) begin : g_sw
            assign src_a = {{(WORD_W-1){1'b0}}, sw[0]};
            assign src_b = {{(WORD_W-1){1'b0}}, sw[1]};
        end else begin : g_reg
            logic unused_sw;
            assign unused_sw = ^sw;
            assign src_a = regs.a;
            assign src_b = regs.b;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == OFS_A)      rdata = src_a;
            else if (addr == OFS_B) rdata = src_b;
        end
    end
endmodule

// File: rtl/apb_led_sw.sv
module apb_led_sw
    import apb_led_sw_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          READ_SWITCH = 1'b1,
    parameter logic [ADDR_W-1:0] OFS_A = 8'h00,
    parameter logic [ADDR_W-1:0] OFS_B = 8'h04
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              sw_a,
    input  logic              sw_b,
    output logic              led
);
    logic              wr_en, rd_en;
    logic [NUM_SW-1:0] sw_sync;
    regs_t             regs;

    assign wr_en   = psel && penable && pwrite;
    assign rd_en   = psel && !pwrite;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    apb_led_sw_sync #(.STAGES(SYNC_STAGES), .N(NUM_SW)) u_sync (
        .clk(pclk), .rstn(presetn), .din({sw_b, sw_a}), .dout(sw_sync)
    );

    apb_led_sw_regs #(.ADDR_W(ADDR_W), .OFS_A(OFS_A), .OFS_B(OFS_B)) u_regs (
        .clk(pclk), .rstn(presetn), .wr_en(wr_en), .wr_addr(paddr),
        .wr_data(pwdata), .regs(regs)
    );

    apb_led_sw_rdmux #(.ADDR_W(ADDR_W), .OFS_A(OFS_A), .OFS_B(OFS_B),
                       .READ_SWITCH(READ_SWITCH)) u_rdmux (
        .rd_en(rd_en), .addr(paddr), .regs(regs), .sw(sw_sync), .rdata(prdata)
    );

    assign led = regs.a[0];

    assert_led_follow_R4: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite && paddr == OFS_A) |=> led == $past(pwdata[0]));
    assert_rd_idle_R10: assert property (@(posedge pclk) disable iff (!presetn)
        (!psel || pwrite) |-> prdata == '0);

    generate
        if (READ_SWITCH) begin : g_chk_sw
            assert_sw_width_R5: assert property (@(posedge pclk) disable iff (!presetn)
                prdata[31:1] == '0);
        end
    endgenerate
endmodule

// File: tb/tb_apb_led_sw.sv
module tb_apb_led_sw;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = 8'h00;
    logic [31:0] pwdata = '0;
    logic        sw_a = 1'b0, sw_b = 1'b0;
    logic [31:0] prdata_sw, prdata_rg;
    logic        pready_sw, pready_rg, pslverr_sw, pslverr_rg, led_sw, led_rg;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_a = '0, exp_b = '0;

    always #5 pclk = ~pclk;

    apb_led_sw dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_sw),
        .pready(pready_sw), .pslverr(pslverr_sw), .sw_a(sw_a), .sw_b(sw_b),
        .led(led_sw)
    );

    apb_led_sw #(.READ_SWITCH(1'b0)) dut_reg (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_rg),
        .pready(pready_rg), .pslverr(pslverr_rg), .sw_a(sw_a), .sw_b(sw_b),
        .led(led_rg)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] r_sw, output logic [31:0] r_rg);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        r_sw = prdata_sw; r_rg = prdata_rg;
        check("R1 pready", {30'b0, pready_sw, pready_rg}, 32'h3);
        check("R1 pslverr", {30'b0, pslverr_sw, pslverr_rg}, 32'h0);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] x, y;
        xfer(1'b1, a, d, x, y);
        if (a == 8'h00) exp_a = d;
        if (a == 8'h04) exp_b = d;
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] x, y;
        xfer(1'b0, 8'h00, 32'hdead_beef, x, y);
        check({tag, " regA"}, y, exp_a);
        xfer(1'b0, 8'h04, 32'hdead_beef, x, y);
        check({tag, " regB"}, y, exp_b);
        check({tag, " R4 led"}, {30'b0, led_sw, led_rg}, {30'b0, exp_a[0], exp_a[0]});
    endtask

    task automatic settle_sw(input logic a, input logic b);
        @(negedge pclk);
        sw_a = a; sw_b = b;
        repeat (3) @(negedge pclk);
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge pclk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] x, y;
        repeat (3) @(negedge pclk);
        #1;
        check("R8 led in reset", {30'b0, led_sw, led_rg}, 32'h0);
        presetn = 1'b1;
        check_regs("R8 after reset");

        // R2 R6: full-word writes, read back in register mode
        wr(8'h00, 32'hA5A5_5A5B); check_regs("R2 R6 write A");
        wr(8'h04, 32'h1234_5678); check_regs("R2 R6 write B");
        wr(8'h00, 32'hFFFF_FFFE); check_regs("R2 R4 led low");

        // R3: strobes that must not store
        @(negedge pclk); psel = 1'b1; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'h0000_0001;
        @(negedge pclk); psel = 1'b0;
        @(negedge pclk); penable = 1'b1; pwrite = 1'b1; paddr = 8'h04; pwdata = 32'h0;
        @(negedge pclk); penable = 1'b0; pwrite = 1'b0;
        xfer(1'b0, 8'h00, 32'h0000_0001, x, y);
        xfer(1'b0, 8'h04, 32'h0000_0000, x, y);
        check_regs("R3 no strobe");

        // R7 R2: write sweep over all offsets
        for (int off = 0; off < 256; off++) begin
            wr(off[7:0], {off[7:0], ~off[7:0], off[7:0] ^ 8'h3C, off[7:0] + 8'd1});
            check_regs("R7 R2 write sweep");
        end

        // R10: deselected or write-direction read data is zero
        @(negedge pclk); psel = 1'b0; pwrite = 1'b0; paddr = 8'h00; #1;
        check("R10 no select", prdata_rg, 32'h0);
        @(negedge pclk); psel = 1'b1; pwrite = 1'b1; paddr = 8'h04; #1;
        check("R10 write dir", prdata_rg, 32'h0);
        @(negedge pclk); psel = 1'b0; pwrite = 1'b0;

        // R5 R6 R7: read sweep over all offsets and switch combinations
        for (int s = 0; s < 4; s++) begin
            settle_sw(s[0], s[1]);
            for (int off = 0; off < 256; off++) begin
                xfer(1'b0, off[7:0], 32'hFFFF_FFFF, x, y);
                if (off == 0) begin
                    check("R5 switch A", x, {31'b0, s[0]});
                    check("R6 reg A", y, exp_a);
                end else if (off == 4) begin
                    check("R5 switch B", x, {31'b0, s[1]});
                    check("R6 reg B", y, exp_b);
                end else begin
                    check("R7 unmapped sw", x, 32'h0);
                    check("R7 unmapped reg", y, 32'h0);
                end
            end
        end

        // R9: two-edge synchronizer latency
        settle_sw(1'b0, 1'b0);
        @(negedge pclk); psel = 1'b1; pwrite = 1'b0; paddr = 8'h00; sw_a = 1'b1;
        @(negedge pclk); #1; check("R9 after one edge", prdata_sw, 32'h0);
        @(negedge pclk); #1; check("R9 after two edges", prdata_sw, 32'h1);
        paddr = 8'h04; sw_b = 1'b1; sw_a = 1'b0;
        @(negedge pclk); #1; check("R9 B after one edge", prdata_sw, 32'h0);
        @(negedge pclk); #1; check("R9 B after two edges", prdata_sw, 32'h1);
        @(negedge pclk); psel = 1'b0;

        // R8: reset mid-run clears registers
        wr(8'h00, 32'h0000_00FF); wr(8'h04, 32'hCAFE_F00D);
        check_regs("R8 before reset");
        @(negedge pclk); presetn = 1'b0;
        @(negedge pclk); #1;
        check("R8 led cleared", {30'b0, led_sw, led_rg}, 32'h0);
        presetn = 1'b1;
        exp_a = '0; exp_b = '0;
        check_regs("R8 cleared");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule